// File: doc/BRIEF.md
# Repeat-Mode DMA Channel with Half-Count Flag

This block is a single DMA channel. Each peripheral request moves one word from a fixed receive register into a memory buffer whose address steps upward. Software sets up the source address, the destination address, a transfer count and a control word through a four-entry register port. When the destination address or the count is written while the channel is disabled, a hidden backup copy is loaded as well.

In repeat mode, the channel restores the destination address and the count from those backups each time the count runs out. The same buffer is then refilled without software having to reprogram it. A half-count flag is raised midway through each pass and an end flag at its end. Software can therefore process one half of the buffer while the other half is being filled. If both flags are left set together, the channel holds off further transfers until software acknowledges them.

The channel runs only when its own enable and the global enable input are both high and the abort input is low. Its memory side is a single-beat request/acknowledge port that carries one access at a time.

Top module: `dmach_top`

## Requirements
- R1: After reset, all four registers read as zero, `irq` is low and `mem_req` is low.
- R2: Each accepted request performs one read at the source address, then one write to the destination address carrying the data that was read. The source address advances by 4 only when the source mode (control bits 13..12) is 2'b01; otherwise it stays fixed. The destination address advances by 4 when the destination mode (control bits 15..14) is 2'b01 and stays fixed for 2'b00.
- R3: The count (register index 2) decreases by one for every completed write.
- R4: The half flag (control bit 19) sets when a decrement produces a count equal to the backup count shifted right by one.
- R5: The end flag (control bit 1) sets when a decrement produces zero. When the repeat field is not 3'b010, the count then stays at zero and no further transfers occur.
- R6: When the repeat field (control bits 27..25) is 3'b010 and the count reaches zero, the count is reloaded from the backup count and the destination address from the backup destination.
- R7: While the half and end flags are both set, no new transfer starts. Transfers resume once either flag is cleared.
- R8: Writing 0 to control bit 19 or bit 1 clears that flag. Writing 1 leaves the flag unchanged and never sets it.
- R9: `irq` equals the interrupt enable (control bit 2) ANDed with the OR of the end flag and the half flag gated by the half enable (control bit 18).
- R10: No transfer starts while the channel enable (control bit 0) is clear, while `master_en` is low, or while `abort_i` is high.
- R11: Writes to the source (index 0), destination (index 1) and count (index 2) registers are ignored while the channel enable is set. While it is clear, a destination or count write also loads the matching backup register. The control register is at index 3.
- R12: `mem_req` stays high with a stable address and direction until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| master_en | input | 1 | Global enable |
| abort_i | input | 1 | Abort; blocks new transfers while high |
| dreq | input | 1 | Peripheral transfer request (level) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |
| mem_ack | input | 1 | Memory access completes this cycle |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the channel with a 16-bit address, an 8-bit count and 32-bit data. With counts of one to five, every pass reaches its half point, its end and the reload within a handful of transfers. A start count of one makes the half point equal zero, so both flags rise on the same decrement and the stall follows at once. The memory model can hold back its acknowledge, which exercises a request that must wait.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
    localparam int DE_BIT  = 0;
    localparam int TE_BIT  = 1;
    localparam int IE_BIT  = 2;
    localparam int SM_LSB  = 12;
    localparam int DM_LSB  = 14;
    localparam int HIE_BIT = 18;
    localparam int HE_BIT  = 19;
    localparam int RPT_LSB = 25;

    localparam logic [2:0] RPT_DST = 3'b010;
    localparam logic [1:0] AM_INC  = 2'b01;

    localparam logic [1:0] IDX_SRC = 2'd0;
    localparam logic [1:0] IDX_DST = 2'd1;
    localparam logic [1:0] IDX_CNT = 2'd2;
    localparam logic [1:0] IDX_CTL = 2'd3;

    typedef enum logic [1:0] {ENG_IDLE, ENG_READ, ENG_WRITE} eng_state_e;

    typedef struct packed {
        logic [2:0] rpt;
        logic [1:0] dm;
        logic [1:0] sm;
        logic       hie;
        logic       he;
        logic       ie;
        logic       te;
        logic       de;
    } ctrl_t;

    function automatic logic [31:0] ctrl_word(input ctrl_t c);
        logic [31:0] w;
        w = '0;
        w[RPT_LSB +: 3] = c.rpt;
        w[DM_LSB +: 2]  = c.dm;
        w[SM_LSB +: 2]  = c.sm;
        w[HIE_BIT]      = c.hie;
        w[HE_BIT]       = c.he;
        w[IE_BIT]       = c.ie;
        w[TE_BIT]       = c.te;
        w[DE_BIT]       = c.de;
        return w;
    endfunction
endpackage

// File: rtl/dmach_engine.sv
module dmach_engine
    import dmach_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] dst,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          done,
    output logic          idle
);
    typedef struct packed {
        eng_state_e    st;
        logic [DW-1:0] data;
    } eng_t;

    eng_t d, q;

    always_comb begin
        d    = q;
        done = 1'b0;
        case (q.st)
            ENG_IDLE:  if (start) d.st = ENG_READ;
            ENG_READ:  if (mem_ack) begin
                d.data = mem_rdata;
                d.st   = ENG_WRITE;
            end
            ENG_WRITE: if (mem_ack) begin
                done = 1'b1;
                d.st = ENG_IDLE;
            end
            default:   d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ENG_IDLE, data: '0};
        else        q <= d;
    end

    assign mem_req   = (q.st == ENG_READ) || (q.st == ENG_WRITE);
    assign mem_we    = (q.st == ENG_WRITE);
    assign mem_addr  = (q.st == ENG_WRITE) ? dst : src;
    assign mem_wdata = q.data;
    assign idle      = (q.st == ENG_IDLE);
endmodule

// File: rtl/dmach_regs.sv
module dmach_regs
    import dmach_pkg::*;
#(
    parameter int AW         = 32,
    parameter int CW         = 16,
    parameter int WORD_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [1:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          eng_idle,
    input  logic          xfer_done,
    output logic [AW-1:0] src,
    output logic [AW-1:0] dst,
    output logic [CW-1:0] cnt,
    output ctrl_t         ctrl,
    output logic          can_run
);
    localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

    typedef struct packed {
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [AW-1:0] bdst;
        logic [CW-1:0] cnt;
        logic [CW-1:0] bcnt;
        ctrl_t         ctrl;
    } regs_t;

    regs_t d, q;
    logic          wr_ok;
    logic [CW-1:0] dec;

    always_comb begin
        d     = q;
        wr_ok = !q.ctrl.de && eng_idle;
        dec   = q.cnt - CW'(1);
        if (reg_we) begin
            case (reg_addr)
                IDX_SRC: if (wr_ok) d.src = reg_wdata[AW-1:0];
                IDX_DST: if (wr_ok) begin
                    d.dst  = reg_wdata[AW-1:0];
                    d.bdst = reg_wdata[AW-1:0];
                end
                IDX_CNT: if (wr_ok) begin
                    d.cnt  = reg_wdata[CW-1:0];
                    d.bcnt = reg_wdata[CW-1:0];
                end
                default: begin
                    d.ctrl.rpt = reg_wdata[RPT_LSB +: 3];
                    d.ctrl.dm  = reg_wdata[DM_LSB +: 2];
                    d.ctrl.sm  = reg_wdata[SM_LSB +: 2];
                    d.ctrl.hie = reg_wdata[HIE_BIT];
                    d.ctrl.ie  = reg_wdata[IE_BIT];
                    d.ctrl.de  = reg_wdata[DE_BIT];
                    d.ctrl.he  = q.ctrl.he & reg_wdata[HE_BIT];
                    d.ctrl.te  = q.ctrl.te & reg_wdata[TE_BIT];
                end
            endcase
        end
        if (xfer_done) begin
            d.cnt = dec;
            if (q.ctrl.sm == AM_INC) d.src = q.src + STEP;
            if (q.ctrl.dm == AM_INC) d.dst = q.dst + STEP;
            if (dec == (q.bcnt >> 1)) d.ctrl.he = 1'b1;
            if (dec == '0) begin
                d.ctrl.te = 1'b1;
                if (q.ctrl.rpt == RPT_DST) begin
                    d.cnt = q.bcnt;
                    d.dst = q.bdst;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (reg_addr)
            IDX_SRC: reg_rdata = 32'(q.src);
            IDX_DST: reg_rdata = 32'(q.dst);
            IDX_CNT: reg_rdata = 32'(q.cnt);
            default: reg_rdata = ctrl_word(q.ctrl);
        endcase
    end

    assign src     = q.src;
    assign dst     = q.dst;
    assign cnt     = q.cnt;
    assign ctrl    = q.ctrl;
    assign can_run = q.ctrl.de && (q.cnt != '0) && !(q.ctrl.he && q.ctrl.te);
endmodule

// File: rtl/dmach_top.sv
module dmach_top
    import dmach_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [1:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          master_en,
    input  logic          abort_i,
    input  logic          dreq,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack,
    output logic          irq
);
    logic [AW-1:0] src_w, dst_w;
    logic [CW-1:0] cnt_w;
    ctrl_t         ctrl_w;
    logic          can_run_w, done_w, idle_w, start_w;

    assign start_w = can_run_w && master_en && !abort_i && dreq;

    dmach_regs #(.AW(AW), .CW(CW), .WORD_BYTES(4)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .eng_idle  (idle_w),
        .xfer_done (done_w),
        .src       (src_w),
        .dst       (dst_w),
        .cnt       (cnt_w),
        .ctrl      (ctrl_w),
        .can_run   (can_run_w)
    );

    dmach_engine #(.AW(AW), .DW(DW)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_w),
        .src       (src_w),
        .dst       (dst_w),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .done      (done_w),
        .idle      (idle_w)
    );

    assign irq = ctrl_w.ie && (ctrl_w.te || (ctrl_w.he && ctrl_w.hie));
endmodule

// File: rtl/dmach_chk.sv
module dmach_chk #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_rdata,
    input logic [DW-1:0] mem_wdata,
    input logic          master_en,
    input logic          he,
    input logic          te,
    input logic [CW-1:0] cnt
);
    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R2
    rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack) |=> (mem_req && mem_we));

    // R2
    data_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack) |=> (mem_wdata == $past(mem_rdata)));

    // R3
    cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack && cnt > CW'(1)) |=> (cnt == $past(cnt) - CW'(1)));

    // R7
    stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (he && te && !mem_req) |=> !mem_req);

    // R10
    master_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_en && !mem_req) |=> !mem_req);
endmodule

bind dmach_top dmach_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .mem_wdata (mem_wdata),
    .master_en (master_en),
    .he        (ctrl_w.he),
    .te        (ctrl_w.te),
    .cnt       (cnt_w)
);

// File: tb/dmach_top_bench.sv
module dmach_top_bench;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int CW = 8;

    localparam logic [1:0] A_SRC = 2'd0, A_DST = 2'd1, A_CNT = 2'd2, A_CTL = 2'd3;
    localparam logic [31:0] B_DE = 32'h1, B_TE = 32'h2, B_IE = 32'h4;
    localparam logic [31:0] B_HIE = 32'h1 << 18, B_HE = 32'h1 << 19;
    localparam logic [15:0] SRC_A = 16'h0040, DST_A = 16'h0100;

    typedef struct packed {
        logic [7:0]  init;
        logic [2:0]  rpt;
        logic [1:0]  dm;
        logic [3:0]  n;
        logic [7:0]  ecnt;
        logic [15:0] edst;
        logic        ehe;
        logic        ete;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{8'd4, 3'b010, 2'b01, 4'd3, 8'd1, 16'h010C, 1'b1, 1'b0},
        '{8'd4, 3'b010, 2'b01, 4'd4, 8'd4, 16'h0100, 1'b1, 1'b1},
        '{8'd4, 3'b000, 2'b01, 4'd2, 8'd2, 16'h0108, 1'b1, 1'b0},
        '{8'd3, 3'b010, 2'b01, 4'd1, 8'd2, 16'h0104, 1'b0, 1'b0},
        '{8'd5, 3'b010, 2'b00, 4'd3, 8'd2, 16'h0100, 1'b1, 1'b0},
        '{8'd1, 3'b010, 2'b01, 4'd1, 8'd1, 16'h0100, 1'b1, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          master_en = 1'b1;
    logic          abort_i = 1'b0;
    logic          dreq = 1'b0;
    logic          mem_req, mem_we, mem_ack, irq;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic          ack_block = 1'b0;
    logic [31:0]   rd_pat = 32'hA5000001;

    int checks = 0;
    int fails = 0;
    int wr_cnt = 0;
    bit finished = 0;

    int          m_cnt, m_init;
    logic [2:0]  m_rpt;
    logic [1:0]  m_dm;
    logic [15:0] m_dst;

    always #5 clk = ~clk;

    assign mem_ack   = mem_req && !ack_block;
    assign mem_rdata = rd_pat;

    always @(posedge clk) if (mem_req && mem_we && mem_ack) wr_cnt <= wr_cnt + 1;

    dmach_top #(.AW(AW), .DW(DW), .CW(CW)) u_dmach_top (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .master_en(master_en),
        .abort_i(abort_i), .dreq(dreq), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    function automatic logic [31:0] ctl_val(input logic [2:0] rpt, input logic [1:0] dm);
        return (32'(rpt) << 25) | (32'(dm) << 14) | B_HIE | B_IE | B_DE;
    endfunction

    task automatic prog(input int init, input logic [2:0] rpt, input logic [1:0] dm);
        reg_wr(A_CTL, 32'h0);
        reg_wr(A_SRC, 32'(SRC_A));
        reg_wr(A_DST, 32'(DST_A));
        reg_wr(A_CNT, 32'(init));
        reg_wr(A_CTL, ctl_val(rpt, dm));
        m_cnt = init; m_init = init; m_rpt = rpt; m_dm = dm; m_dst = DST_A;
    endtask

    task automatic do_xfer(output bit done);
        done = 1'b0;
        @(negedge clk);
        dreq = 1'b1;
        for (int i = 0; i < 8 && !done; i++) begin
            @(negedge clk);
            if (mem_req && !mem_we) check("R2 read addr", 32'(mem_addr), 32'(SRC_A));
            if (mem_req && mem_we) begin
                check("R2 write addr", 32'(mem_addr), 32'(m_dst));
                check("R2 write data", mem_wdata, rd_pat);
                done = 1'b1;
            end
        end
        dreq = 1'b0;
        if (done) begin
            rd_pat = rd_pat + 32'h11;
            if (m_dm == 2'b01) m_dst = m_dst + 16'd4;
            m_cnt = m_cnt - 1;
            if (m_cnt == 0 && m_rpt == 3'b010) begin
                m_cnt = m_init;
                m_dst = DST_A;
            end
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        bit done;
        int w0;

        repeat (3) @(negedge clk);
        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            reg_rd(2'(a), v);
            check("R1 reg after reset", v, 32'h0);
        end
        check("R1 irq after reset", 32'(irq), 32'h0);
        check("R1 mem_req after reset", 32'(mem_req), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 mem_req idle", 32'(mem_req), 32'h0);

        // vector table: R2 R3 R4 R5 R6 R9
        for (int k = 0; k < 6; k++) begin
            prog(int'(VECS[k].init), VECS[k].rpt, VECS[k].dm);
            w0 = wr_cnt;
            for (int t = 0; t < int'(VECS[k].n); t++) begin
                do_xfer(done);
                check("R2 transfer happened", 32'(done), 32'h1);
            end
            check("R3 write count", 32'(wr_cnt - w0), 32'(VECS[k].n));
            reg_rd(A_CNT, v); check("R3/R6 count", v, 32'(VECS[k].ecnt));
            check("R3 model count", v, 32'(m_cnt));
            reg_rd(A_DST, v); check("R2/R6 dst", v, 32'(VECS[k].edst));
            reg_rd(A_CTL, v);
            check("R4 half flag", 32'(v[19]), 32'(VECS[k].ehe));
            check("R5 end flag", 32'(v[1]), 32'(VECS[k].ete));
            check("R9 irq", 32'(irq), 32'(VECS[k].ehe | VECS[k].ete));
        end

        // R7: stall with both flags, resume after clearing end flag
        prog(4, 3'b010, 2'b01);
        for (int t = 0; t < 4; t++) do_xfer(done);
        w0 = wr_cnt;
        do_xfer(done);
        check("R7 stalled with both flags", 32'(done), 32'h0);
        check("R7 no write while stalled", 32'(wr_cnt - w0), 32'h0);
        reg_wr(A_CTL, ctl_val(3'b010, 2'b01) | B_HE);
        do_xfer(done);
        check("R7 resumes after clear", 32'(done), 32'h1);
        reg_rd(A_CTL, v);
        check("R8 writing 1 keeps half flag", 32'(v[19]), 32'h1);
        check("R8 writing 0 clears end flag", 32'(v[1]), 32'h0);
        reg_rd(A_CNT, v); check("R6 count after reload and step", v, 32'd3);

        // R8: writing 1 never sets a flag
        reg_wr(A_CTL, 32'h0);
        reg_wr(A_CTL, B_HE | B_TE | B_IE | B_HIE);
        reg_rd(A_CTL, v);
        check("R8 half flag not set by write", 32'(v[19]), 32'h0);
        check("R8 end flag not set by write", 32'(v[1]), 32'h0);
        check("R9 irq low with no flags", 32'(irq), 32'h0);

        // R10: each gate blocks a transfer
        prog(4, 3'b010, 2'b01);
        master_en = 1'b0;
        do_xfer(done); check("R10 blocked by master_en", 32'(done), 32'h0);
        master_en = 1'b1; abort_i = 1'b1;
        do_xfer(done); check("R10 blocked by abort", 32'(done), 32'h0);
        abort_i = 1'b0;
        reg_wr(A_CTL, ctl_val(3'b010, 2'b01) & ~B_DE);
        do_xfer(done); check("R10 blocked by channel enable", 32'(done), 32'h0);
        reg_wr(A_CTL, ctl_val(3'b010, 2'b01));
        do_xfer(done); check("R10 runs when all enables set", 32'(done), 32'h1);

        // R11: writes ignored while enabled
        reg_wr(A_DST, 32'h0F00);
        reg_rd(A_DST, v); check("R11 dst write ignored", v, 32'h0104);
        reg_wr(A_CNT, 32'd9);
        reg_rd(A_CNT, v); check("R11 count write ignored", v, 32'd3);
        reg_wr(A_SRC, 32'h0999);
        reg_rd(A_SRC, v); check("R11 src write ignored", v, 32'(SRC_A));

        // R5: single pass without repeat stops at zero
        prog(2, 3'b000, 2'b01);
        do_xfer(done);
        reg_rd(A_CTL, v); check("R4 half at one", 32'(v[19]), 32'h1);
        reg_wr(A_CTL, ctl_val(3'b000, 2'b01));
        do_xfer(done);
        reg_rd(A_CTL, v); check("R5 end flag at zero", 32'(v[1]), 32'h1);
        check("R9 irq on end flag", 32'(irq), 32'h1);
        reg_wr(A_CTL, ctl_val(3'b000, 2'b01));
        check("R9 irq cleared", 32'(irq), 32'h0);
        do_xfer(done);
        check("R5 no transfer at zero", 32'(done), 32'h0);
        reg_rd(A_CNT, v); check("R5 count stays zero", v, 32'h0);

        // R12: request held while acknowledge is withheld
        prog(4, 3'b010, 2'b01);
        w0 = wr_cnt;
        ack_block = 1'b1;
        @(negedge clk); dreq = 1'b1;
        repeat (4) @(negedge clk);
        dreq = 1'b0;
        check("R12 request held", 32'(mem_req), 32'h1);
        check("R12 still reading", 32'(mem_we), 32'h0);
        check("R12 address held", 32'(mem_addr), 32'(SRC_A));
        ack_block = 1'b0;
        repeat (3) @(negedge clk);
        check("R12 completes after ack", 32'(wr_cnt - w0), 32'h1);
        check("R12 idle after completion", 32'(mem_req), 32'h0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule